// File: doc/BRIEF.md
# Keyed Configuration Port with Flash-Control Registers

This block is the configuration front end of a peripheral controller, reached through a pair of byte-wide I/O ports: an index port that picks a register and a data port that reads or writes it. Out of reset the register file is hidden. The host must first write a four-byte unlock key to the index port. The last byte of that key depends on which of two configuration addresses the controller is strapped to. After that, index writes select registers and data accesses reach them. A specific value written to the exit register hides the file again.

While unlocked, the host can read a fixed 16-bit chip identifier and a revision byte. It can also select a logical device and program a global flash-control register. That register carries the suspend flag, three address-window segment enables, the host-write-to-flash enable and an output-pin choice. The host can also program the flash command port base and pick one of two flash chips. The last two are reached only while the flash logical device is selected. The stored settings drive the block's outputs continuously, whether the file is locked or not.

Top module: `cfg_key_port`

## Requirements
- R1: After reset the block is locked, `rdata` reads 0xFF, and every writable register is zero: `base_port`, `seg_en`, `suspend`, `flash_wr_en`, `pin_sel` and `flash_sel` are 0, and global register 0x24 reads 0x00 once unlocked.
- R2: With `alt_strap`=0, the consecutive index writes 0x87, 0x01, 0x55, 0x55 set `unlocked` on the clock edge that takes the fourth byte.
- R3: With `alt_strap`=1, the fourth key byte must be 0xAA. The sequence 0x87, 0x01, 0x55, 0x55 leaves the block locked.
- R4: Any index write that does not match the expected key byte returns the matcher to its first state. That byte is not re-examined as a new first byte. A complete correct key afterwards still unlocks.
- R5: While locked, data-port writes change no register and data-port reads return 0xFF.
- R6: Register 0x20 reads the high byte and 0x21 the low byte of the chip identifier (parameter CHIP_ID). Register 0x22 reads the revision (parameter CHIP_REV). Writes to these registers have no effect.
- R7: Global register 0x24 maps bit 0 to `suspend`, bits 3:1 to `seg_en[2:0]`, bit 4 to `flash_wr_en` and bit 5 to `pin_sel`. Bits 7:6 read 0.
- R8: `xlate_active` is 1 exactly when at least one of bits 3:1 of register 0x24 is set.
- R9: Register 0x07 is the read/write logical-device select. With device 0x07 selected, register 0x64 holds `base_port[15:8]` and register 0x65 holds `base_port[7:0]`. Bits 2:0 of the base are always zero, so 8-byte alignment is enforced on write and read back as zero.
- R10: When the selected logical device is not 0x07, registers 0x64, 0x65 and 0xEF read 0x00 and ignore writes.
- R11: With device 0x07 selected, bit 0 of register 0xEF selects the active flash chip (`flash_sel`) and reads back as written. Its other bits read 0.
- R12: Writing 0x02 to register 0x02 clears `unlocked` on that edge. Writing any other value there leaves the block unlocked.
- R13: Unmapped registers read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alt_strap | input | 1 | 0: primary address key (last byte 0x55); 1: alternate address key (last byte 0xAA) |
| idx_wr | input | 1 | Index-port write strobe, one cycle per byte |
| data_wr | input | 1 | Data-port write strobe, one cycle per byte |
| wdata | input | 8 | Byte written to the index or data port |
| rdata | output | 8 | Data-port read value for the current index; 0xFF while locked |
| unlocked | output | 1 | Configuration mode is active |
| suspend | output | 1 | Suspend flag, register 0x24 bit 0 |
| seg_en | output | 3 | Address-window segment enables, register 0x24 bits 3:1 |
| xlate_active | output | 1 | Any segment enabled |
| flash_wr_en | output | 1 | Host writes to flash allowed, register 0x24 bit 4 |
| pin_sel | output | 1 | Flash output pin choice, register 0x24 bit 5 |
| flash_sel | output | 1 | Active flash chip, device 7 register 0xEF bit 0 |
| base_port | output | 16 | Flash command port base, 8-byte aligned |

## Verification
The assertions watch the unlock and lock transitions on every cycle. Unlocking may only follow an index write of the strap-dependent last key byte. An exit write must relock on the next edge. The key matcher must sit idle while unlocked. Every stored register must hold still while locked, and the base port must not move when a write arrives with another logical device selected. The read-back values, the bit-field mapping of the global register, the alignment masking, the identifier bytes and the recovery of the matcher after broken keys can only be shown by the bench's access sequences.

// File: rtl/cfg_key_pkg.sv
package cfg_key_pkg;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_GOT1 = 2'd1,
    K_GOT2 = 2'd2,
    K_GOT3 = 2'd3
  } key_state_t;

  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_B3_PRI  = 8'h55;
  localparam logic [7:0] KEY_B3_ALT  = 8'hAA;

  localparam logic [7:0] REG_EXIT    = 8'h02;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] REG_GCTL    = 8'h24;
  localparam logic [7:0] REG_BASE_HI = 8'h64;
  localparam logic [7:0] REG_BASE_LO = 8'h65;
  localparam logic [7:0] REG_CSEL    = 8'hEF;
  localparam logic [7:0] LDN_FLASH   = 8'h07;

  function automatic logic [7:0] key_expect(key_state_t st, logic alt);
    case (st)
      K_IDLE:  key_expect = KEY_B0;
      K_GOT1:  key_expect = KEY_B1;
      K_GOT2:  key_expect = KEY_B2;
      default: key_expect = alt ? KEY_B3_ALT : KEY_B3_PRI;
    endcase
  endfunction

endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match
  import cfg_key_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alt_i,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exit_i,
  output logic       unlocked_o
);

  key_state_t kst_q, kst_d;
  logic       unl_q, unl_d;
  logic       hit;

  always_comb begin
    kst_d = kst_q;
    unl_d = unl_q;
    hit   = 1'b0;
    if (unl_q) begin
      kst_d = K_IDLE;
      if (exit_i) unl_d = 1'b0;
    end else if (idx_wr_i) begin
      if (wdata_i == key_expect(kst_q, alt_i)) begin
        case (kst_q)
          K_IDLE:  kst_d = K_GOT1;
          K_GOT1:  kst_d = K_GOT2;
          K_GOT2:  kst_d = K_GOT3;
          default: begin
            kst_d = K_IDLE;
            hit   = 1'b1;
          end
        endcase
      end else begin
        kst_d = K_IDLE;
      end
      if (hit) unl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kst_q <= K_IDLE;
      unl_q <= 1'b0;
    end else begin
      kst_q <= kst_d;
      unl_q <= unl_d;
    end
  end

  assign unlocked_o = unl_q;

  // R2 R3
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> ($past(idx_wr_i) &&
      $past(wdata_i) == ($past(alt_i) ? KEY_B3_ALT : KEY_B3_PRI)));

  // R12
  exit_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unl_q && exit_i) |=> !unl_q);

  // R4
  matcher_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(unl_q) |-> (kst_q == K_IDLE));

endmodule

// File: rtl/cfg_key_regs.sv
module cfg_key_regs
  import cfg_key_pkg::*;
#(
  parameter logic [15:0] CHIP_ID    = 16'hC3A7,
  parameter logic [7:0]  CHIP_REV   = 8'h11,
  parameter int          ALIGN_BITS = 3,
  parameter int          GCTL_BITS  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unlocked_i,
  input  logic        idx_wr_i,
  input  logic        data_wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        exit_o,
  output logic [GCTL_BITS-1:0] gctl_o,
  output logic        csel_o,
  output logic [15:0] base_o
);

  localparam int LO_KEEP = 8 - ALIGN_BITS;

  logic [7:0]           idx_q, idx_d;
  logic [7:0]           ldn_q, ldn_d;
  logic [GCTL_BITS-1:0] gctl_q, gctl_d;
  logic [7:0]           bhi_q, bhi_d;
  logic [LO_KEEP-1:0]   blo_q, blo_d;
  logic                 csel_q, csel_d;
  logic                 wr_ok;
  logic                 dev_flash;

  assign wr_ok     = unlocked_i & data_wr_i;
  assign dev_flash = (ldn_q == LDN_FLASH);

  always_comb begin
    idx_d  = idx_q;
    ldn_d  = ldn_q;
    gctl_d = gctl_q;
    bhi_d  = bhi_q;
    blo_d  = blo_q;
    csel_d = csel_q;
    if (unlocked_i && idx_wr_i) idx_d = wdata_i;
    if (wr_ok) begin
      case (idx_q)
        REG_LDN:  ldn_d  = wdata_i;
        REG_GCTL: gctl_d = wdata_i[GCTL_BITS-1:0];
        REG_BASE_HI: if (dev_flash) bhi_d = wdata_i;
        REG_BASE_LO: if (dev_flash) blo_d = wdata_i[7:ALIGN_BITS];
        REG_CSEL:    if (dev_flash) csel_d = wdata_i[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ldn_q  <= '0;
      gctl_q <= '0;
      bhi_q  <= '0;
      blo_q  <= '0;
      csel_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      ldn_q  <= ldn_d;
      gctl_q <= gctl_d;
      bhi_q  <= bhi_d;
      blo_q  <= blo_d;
      csel_q <= csel_d;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    case (idx_q)
      REG_LDN:     rdata_o = ldn_q;
      REG_ID_HI:   rdata_o = CHIP_ID[15:8];
      REG_ID_LO:   rdata_o = CHIP_ID[7:0];
      REG_REV:     rdata_o = CHIP_REV;
      REG_GCTL:    rdata_o = {{(8-GCTL_BITS){1'b0}}, gctl_q};
      REG_BASE_HI: if (dev_flash) rdata_o = bhi_q;
      REG_BASE_LO: if (dev_flash) rdata_o = {blo_q, {ALIGN_BITS{1'b0}}};
      REG_CSEL:    if (dev_flash) rdata_o = {7'd0, csel_q};
      default: ;
    endcase
  end

  assign exit_o = wr_ok && (idx_q == REG_EXIT) && (wdata_i == EXIT_CODE);
  assign gctl_o = gctl_q;
  assign csel_o = csel_q;
  assign base_o = {bhi_q, blo_q, {ALIGN_BITS{1'b0}}};

  // R5
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_i |=> ($stable(gctl_q) && $stable(ldn_q) && $stable(bhi_q) &&
                     $stable(blo_q) && $stable(csel_q)));

  // R10
  other_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked_i && data_wr_i && !dev_flash) |=> ($stable(base_o) && $stable(csel_q)));

endmodule

// File: rtl/cfg_key_port.sv
module cfg_key_port
  import cfg_key_pkg::*;
#(
  parameter logic [15:0] CHIP_ID    = 16'hC3A7,
  parameter logic [7:0]  CHIP_REV   = 8'h11,
  parameter int          ALIGN_BITS = 3,
  parameter int          SEG_CNT    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alt_strap,
  input  logic               idx_wr,
  input  logic               data_wr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic               unlocked,
  output logic               suspend,
  output logic [SEG_CNT-1:0] seg_en,
  output logic               xlate_active,
  output logic               flash_wr_en,
  output logic               pin_sel,
  output logic               flash_sel,
  output logic [15:0]        base_port
);

  localparam int GCTL_BITS = SEG_CNT + 3;

  logic [1:0]           rst_sync_q;
  logic                 rst_li;
  logic                 exit_req;
  logic [7:0]           reg_rdata;
  logic [GCTL_BITS-1:0] gctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_li = rst_sync_q[1];

  cfg_key_match u_match (
    .clk        (clk),
    .rst_n      (rst_li),
    .alt_i      (alt_strap),
    .idx_wr_i   (idx_wr),
    .wdata_i    (wdata),
    .exit_i     (exit_req),
    .unlocked_o (unlocked)
  );

  cfg_key_regs #(
    .CHIP_ID    (CHIP_ID),
    .CHIP_REV   (CHIP_REV),
    .ALIGN_BITS (ALIGN_BITS),
    .GCTL_BITS  (GCTL_BITS)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_li),
    .unlocked_i (unlocked),
    .idx_wr_i   (idx_wr),
    .data_wr_i  (data_wr),
    .wdata_i    (wdata),
    .rdata_o    (reg_rdata),
    .exit_o     (exit_req),
    .gctl_o     (gctl),
    .csel_o     (flash_sel),
    .base_o     (base_port)
  );

  assign rdata        = unlocked ? reg_rdata : 8'hFF;
  assign suspend      = gctl[0];
  assign seg_en       = gctl[SEG_CNT:1];
  assign xlate_active = |gctl[SEG_CNT:1];
  assign flash_wr_en  = gctl[SEG_CNT+1];
  assign pin_sel      = gctl[SEG_CNT+2];

endmodule

// File: tb/cfg_key_port_tb_top.sv
module cfg_key_port_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] T_ID  = 16'hC3A7;
  localparam logic [7:0]  T_REV = 8'h11;
  localparam logic [3:0]  IW = 4'd0, DW = 4'd1, RD = 4'd2;
  localparam int NV = 52;
  // {op, requirement number, data or expected read}
  localparam logic [19:0] VEC [NV] = '{
    {RD, 8'd5,  8'hFF},  // R5 locked read
    {DW, 8'd0,  8'h3E},  // R5 locked write, ignored
    {IW, 8'd0,  8'h87},  // R2 key
    {IW, 8'd0,  8'h01},
    {IW, 8'd0,  8'h55},
    {IW, 8'd0,  8'h55},
    {IW, 8'd0,  8'h24},
    {RD, 8'd5,  8'h00},  // R5 R1 global still zero
    {IW, 8'd0,  8'h20},
    {RD, 8'd6,  8'hC3},  // R6 id high
    {IW, 8'd0,  8'h21},
    {RD, 8'd6,  8'hA7},  // R6 id low
    {IW, 8'd0,  8'h22},
    {RD, 8'd6,  8'h11},  // R6 revision
    {DW, 8'd0,  8'h77},
    {RD, 8'd6,  8'h11},  // R6 read-only
    {IW, 8'd0,  8'h24},
    {DW, 8'd0,  8'h3E},
    {RD, 8'd7,  8'h3E},  // R7
    {DW, 8'd0,  8'hFF},
    {RD, 8'd7,  8'h3F},  // R7 bits 7:6 zero
    {IW, 8'd0,  8'h07},
    {DW, 8'd0,  8'h07},
    {RD, 8'd9,  8'h07},  // R9 ldn
    {IW, 8'd0,  8'h64},
    {DW, 8'd0,  8'h0A},
    {RD, 8'd9,  8'h0A},  // R9 base high
    {IW, 8'd0,  8'h65},
    {DW, 8'd0,  8'h2F},
    {RD, 8'd9,  8'h28},  // R9 alignment
    {IW, 8'd0,  8'hEF},
    {DW, 8'd0,  8'hFF},
    {RD, 8'd11, 8'h01},  // R11
    {IW, 8'd0,  8'h07},
    {DW, 8'd0,  8'h03},
    {IW, 8'd0,  8'h64},
    {RD, 8'd10, 8'h00},  // R10 hidden
    {DW, 8'd0,  8'h55},
    {IW, 8'd0,  8'h07},
    {DW, 8'd0,  8'h07},
    {IW, 8'd0,  8'h64},
    {RD, 8'd10, 8'h0A},  // R10 write was ignored
    {IW, 8'd0,  8'h30},
    {DW, 8'd0,  8'h5A},
    {RD, 8'd13, 8'h00},  // R13
    {IW, 8'd0,  8'h02},
    {DW, 8'd0,  8'h01},
    {IW, 8'd0,  8'h24},
    {RD, 8'd12, 8'h3F},  // R12 still unlocked
    {IW, 8'd0,  8'h02},
    {DW, 8'd0,  8'h02},
    {RD, 8'd12, 8'hFF}   // R12 relocked
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_strap = 1'b0;
  logic        idx_wr = 1'b0;
  logic        data_wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        unlocked, suspend, xlate_active, flash_wr_en, pin_sel, flash_sel;
  logic [2:0]  seg_en;
  logic [15:0] base_port;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_key_port #(.CHIP_ID(T_ID), .CHIP_REV(T_REV), .ALIGN_BITS(3), .SEG_CNT(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .alt_strap(alt_strap), .idx_wr(idx_wr),
    .data_wr(data_wr), .wdata(wdata), .rdata(rdata), .unlocked(unlocked),
    .suspend(suspend), .seg_en(seg_en), .xlate_active(xlate_active),
    .flash_wr_en(flash_wr_en), .pin_sel(pin_sel), .flash_sel(flash_sel),
    .base_port(base_port)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_idx(logic [7:0] b);
    @(negedge clk); idx_wr = 1'b1; wdata = b;
    @(negedge clk); idx_wr = 1'b0;
  endtask

  task automatic wr_dat(logic [7:0] b);
    @(negedge clk); data_wr = 1'b1; wdata = b;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic send_key(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d);
    wr_idx(a); wr_idx(b); wr_idx(c); wr_idx(d);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 unlocked", {15'd0, unlocked}, 16'd0);
    chk("R1 rdata", {8'd0, rdata}, 16'h00FF);
    chk("R1 base_port", base_port, 16'h0000);
    chk("R1 controls", {10'd0, seg_en, suspend, flash_wr_en, pin_sel}, 16'd0);
    chk("R1 flash_sel", {15'd0, flash_sel}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      logic [7:0] rq;
      logic [7:0] dv;
      op = VEC[i][19:16];
      rq = VEC[i][15:8];
      dv = VEC[i][7:0];
      if (op == IW) wr_idx(dv);
      else if (op == DW) wr_dat(dv);
      else chk($sformatf("R%0d vector %0d", rq, i), {8'd0, rdata}, {8'd0, dv});
    end

    // R7 R9 R11 outputs hold stored settings after relock
    chk("R7 suspend", {15'd0, suspend}, 16'd1);
    chk("R7 seg_en", {13'd0, seg_en}, 16'd7);
    chk("R7 wr_en/pin", {14'd0, flash_wr_en, pin_sel}, 16'd3);
    chk("R8 xlate on", {15'd0, xlate_active}, 16'd1);
    chk("R9 base_port", base_port, 16'h0A28);
    chk("R11 flash_sel", {15'd0, flash_sel}, 16'd1);

    // R4 broken sequences
    send_key(8'h87, 8'h01, 8'h12, 8'h55);
    wr_idx(8'h55);
    chk("R4 broken key", {15'd0, unlocked}, 16'd0);
    send_key(8'h87, 8'h87, 8'h01, 8'h55);
    wr_idx(8'h55);
    chk("R4 repeated first byte", {15'd0, unlocked}, 16'd0);
    send_key(8'h87, 8'h01, 8'h55, 8'h55);
    chk("R4 recovery", {15'd0, unlocked}, 16'd1);

    // R8 translation flag
    wr_idx(8'h24);
    wr_dat(8'h31);
    chk("R8 xlate off", {15'd0, xlate_active}, 16'd0);
    chk("R8 seg_en off", {13'd0, seg_en}, 16'd0);
    chk("R7 wr_en/pin kept", {14'd0, flash_wr_en, pin_sel}, 16'd3);
    wr_dat(8'h04);
    chk("R8 xlate single", {15'd0, xlate_active}, 16'd1);
    chk("R7 seg_en middle", {13'd0, seg_en}, 16'd2);
    wr_idx(8'h02);
    wr_dat(8'h02);
    chk("R12 relock", {15'd0, unlocked}, 16'd0);

    // R3 alternate strap, R1 after second reset
    alt_strap = 1'b1;
    do_reset();
    chk("R1 base after reset", base_port, 16'h0000);
    chk("R1 flash_sel after reset", {15'd0, flash_sel}, 16'd0);
    send_key(8'h87, 8'h01, 8'h55, 8'h55);
    chk("R3 primary key rejected", {15'd0, unlocked}, 16'd0);
    send_key(8'h87, 8'h01, 8'h55, 8'hAA);
    chk("R3 alternate key", {15'd0, unlocked}, 16'd1);
    wr_idx(8'h24);
    chk("R1 global zero", {8'd0, rdata}, 16'h0000);

    finish_run();
  end

endmodule